// File: doc/BRIEF.md
# Instruction Fetch Translation Checker

The block turns the virtual address of an instruction fetch into a physical address, or into a fault code, under the control of a 64-bit processor control word. It takes the hypervisor, reset-state, privilege, address-mask and fetch-MMU-enable flags from that word, together with the partition number, trap level and primary context. From these it picks the context and the kind of lookup, and it runs the bypass, alignment and range checks before it asks the translation buffer for anything.

Each fetch is one request. The block holds the request, presents one lookup (virtual address, partition, context, real/virtual flag) on a request/acknowledge port to the translation buffer, and waits for the answer. On a hit it merges the entry's page frame with the page offset, where the page size comes from the entry. On a miss it also produces the tag value that software uses to refill the buffer. Every request ends with a single-cycle response that carries either the physical address or a fault code.

The controller has three states:
- `ST_IDLE` accepts a request. It goes to `ST_RESP` when the request is bypassed or fails a pre-check (transition *early-finish*), and to `ST_LOOKUP` otherwise (transition *issue*).
- `ST_LOOKUP` drives the lookup until the buffer acknowledges it (transition *answer*), then goes to `ST_RESP`.
- `ST_RESP` presents the result for one cycle and returns to `ST_IDLE` (transition *retire*).

Top module: `itfx_fetch_xlate`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `req_ready` is 1 and `rsp_valid`, `tlb_req` and `tag_we` are 0. A reset in the middle of a lookup drops the lookup.
- R2: Control word fields sit at these positions: bit 0 hypervisor, bit 1 reset-state, bit 2 privileged, bit 3 address mask, bit 4 fetch-MMU enable, bits 15:8 partition, bits 18:16 trap level, bits 47:32 primary context. A lookup shows the partition on `tlb_part`. `tlb_ctx` is 0 when the trap level is nonzero and the primary context otherwise. `tlb_req` and its fields stay stable until `tlb_ack`.
- R3: When bit 0 or bit 1 is set, no lookup is issued. The response has fault code 0 and a physical address equal to the low 40 bits of the virtual address, and no alignment or range check applies.
- R4: On a non-bypassed fetch whose address has bit 1 or bit 0 set, the block issues no lookup and returns fault code 1 (misaligned). This check comes before the range check.
- R5: With bit 3 set, the virtual address is cut to its low 32 bits before the range check and the lookup. An address is in range when bits 63:47 are all equal. Otherwise the block returns fault code 2 and issues no lookup.
- R6: With bit 4 clear, the lookup is real (`tlb_real` = 1) and `tlb_ctx` is 0, whatever the trap level or primary context.
- R7: When the buffer answers without a hit, or with an entry that is not valid, the block returns fault code 3. In the same cycle it pulses `tag_we`, with `tag_val` set to the virtual address with bits 12:0 cleared, ORed with the context of the lookup.
- R8: When bit 2 is clear and the hit entry is marked privileged, the block returns fault code 4. A privileged fetch to such a page translates normally.
- R9: On a permitted hit, the page size code s (0..3) selects an offset of 13+3*s bits. The physical address takes these offset bits from the virtual address and the bits above them from `tlb_frame`.
- R10: Each accepted request yields exactly one `rsp_valid` pulse of one cycle. `rsp_paddr` is 0 when the fault code is nonzero. `req_ready` is low from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request strobe, taken while `req_ready` is high |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | 64 | Fetch virtual address |
| ctl_word | input | 64 | Processor control word |
| tlb_req | output | 1 | Lookup request to the translation buffer |
| tlb_vaddr | output | 64 | Lookup virtual address (after masking) |
| tlb_part | output | 8 | Lookup partition |
| tlb_ctx | output | 16 | Lookup context |
| tlb_real | output | 1 | Lookup is real rather than virtual |
| tlb_ack | input | 1 | Buffer answers the lookup this cycle |
| tlb_hit | input | 1 | An entry matched |
| tlb_valid | input | 1 | The matched entry is valid |
| tlb_frame | input | 40 | Physical frame of the entry |
| tlb_psz | input | 2 | Page size code of the entry |
| tlb_priv | input | 1 | Entry is restricted to privileged code |
| rsp_valid | output | 1 | Result is presented this cycle |
| rsp_fault | output | 3 | Fault code: 0 none, 1 misaligned, 2 out of range, 3 miss, 4 privilege |
| rsp_paddr | output | 40 | Physical address (0 on a fault) |
| tag_we | output | 1 | Tag value is to be written (miss only) |
| tag_val | output | 64 | Tag value for refill |

## Verification
The assertions take three things for granted about the translation buffer. It raises `tlb_ack` only while `tlb_req` is high. Its hit, valid, frame, size and privilege inputs are meaningful in the acknowledge cycle. It keeps `tlb_psz` within the four codes. The stimulus keeps to these rules by deriving the acknowledge from `tlb_req` gated with a bench enable. It holds the answer fields constant for the whole of each request, and stretches the wait only by withholding that enable, which exercises the hold rule of the lookup.

// File: rtl/itfx_pkg.sv
package itfx_pkg;
    localparam int CTL_W     = 64;
    localparam int PART_W    = 8;
    localparam int TL_W      = 3;
    localparam int CTX_W     = 16;

    // control word field positions (decoded by the processor's state logic)
    localparam int BIT_HYP   = 0;
    localparam int BIT_RSTM  = 1;
    localparam int BIT_PRIV  = 2;
    localparam int BIT_AMASK = 3;
    localparam int BIT_MMU   = 4;
    localparam int PART_LO   = 8;
    localparam int TL_LO     = 16;
    localparam int CTX_LO    = 32;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ALIGN = 3'd1,
        FLT_RANGE = 3'd2,
        FLT_MISS  = 3'd3,
        FLT_PRIV  = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_RESP   = 2'd2
    } state_e;

    typedef struct packed {
        logic              hyp;
        logic              rstm;
        logic              priv;
        logic              amask;
        logic              mmu_en;
        logic [PART_W-1:0] part;
        logic [TL_W-1:0]   tl;
        logic [CTX_W-1:0]  pctx;
    } ctl_t;
endpackage

// File: rtl/itfx_ctl_decode.sv
module itfx_ctl_decode
    import itfx_pkg::*;
(
    input  logic [CTL_W-1:0]  ctl_word,
    output logic              bypass,
    output logic              real_lk,
    output logic              priv,
    output logic              amask,
    output logic [PART_W-1:0] part,
    output logic [CTX_W-1:0]  ctx_sel
);
    ctl_t f;
    logic unused_ctl_bits;

    always_comb begin
        f.hyp    = ctl_word[BIT_HYP];
        f.rstm   = ctl_word[BIT_RSTM];
        f.priv   = ctl_word[BIT_PRIV];
        f.amask  = ctl_word[BIT_AMASK];
        f.mmu_en = ctl_word[BIT_MMU];
        f.part   = ctl_word[PART_LO +: PART_W];
        f.tl     = ctl_word[TL_LO +: TL_W];
        f.pctx   = ctl_word[CTX_LO +: CTX_W];
    end

    assign unused_ctl_bits = ^{ctl_word[PART_LO-1:BIT_MMU+1],
                               ctl_word[CTX_LO-1:TL_LO+TL_W],
                               ctl_word[CTL_W-1:CTX_LO+CTX_W]};

    always_comb begin
        bypass  = f.hyp | f.rstm;
        real_lk = ~f.mmu_en;
        priv    = f.priv;
        amask   = f.amask;
        part    = f.part;
        // nucleus context is 0; a real lookup carries no context either
        ctx_sel = (real_lk || (f.tl != '0)) ? '0 : f.pctx;
    end
endmodule

// File: rtl/itfx_addr_check.sv
module itfx_addr_check #(
    parameter int VA_W       = 64,
    parameter int VA_IMPL    = 48,
    parameter int AM_W       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic [VA_W-1:0] va_in,
    input  logic            amask,
    output logic [VA_W-1:0] va_eff,
    output logic            misaligned,
    output logic            out_of_range
);
    localparam int TOP_W = VA_W - VA_IMPL + 1;

    logic [TOP_W-1:0] top_bits;

    always_comb begin
        va_eff = va_in;
        if (amask) begin
            va_eff[VA_W-1:AM_W] = '0;
        end
        misaligned   = |va_in[ALIGN_BITS-1:0];
        top_bits     = va_eff[VA_W-1:VA_IMPL-1];
        out_of_range = !((&top_bits) || !(|top_bits));
    end
endmodule

// File: rtl/itfx_page_merge.sv
module itfx_page_merge #(
    parameter int PA_W      = 40,
    parameter int PSZ_W     = 2,
    parameter int PAGE_BASE = 13,
    parameter int PAGE_STEP = 3
) (
    input  logic [PA_W-1:0]  frame,
    input  logic [PSZ_W-1:0] psz,
    input  logic [PA_W-1:0]  va_low,
    output logic [PA_W-1:0]  paddr
);
    localparam int NSZ = 1 << PSZ_W;

    logic [PA_W-1:0] off_mask [NSZ];
    logic [PA_W-1:0] sel_mask;

    genvar g;
    generate
        for (g = 0; g < NSZ; g++) begin : g_size
            localparam int SH = PAGE_BASE + PAGE_STEP * g;
            assign off_mask[g] = (PA_W'(1) << SH) - PA_W'(1);
        end
    endgenerate

    always_comb begin
        sel_mask = off_mask[psz];
        paddr    = (frame & ~sel_mask) | (va_low & sel_mask);
    end
endmodule

// File: rtl/itfx_fetch_xlate.sv
module itfx_fetch_xlate
    import itfx_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 40,
    parameter int VA_IMPL   = 48,
    parameter int PSZ_W     = 2,
    parameter int PAGE_BASE = 13,
    parameter int PAGE_STEP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [CTL_W-1:0]  ctl_word,
    output logic              tlb_req,
    output logic [VA_W-1:0]   tlb_vaddr,
    output logic [PART_W-1:0] tlb_part,
    output logic [CTX_W-1:0]  tlb_ctx,
    output logic              tlb_real,
    input  logic              tlb_ack,
    input  logic              tlb_hit,
    input  logic              tlb_valid,
    input  logic [PA_W-1:0]   tlb_frame,
    input  logic [PSZ_W-1:0]  tlb_psz,
    input  logic              tlb_priv,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              tag_we,
    output logic [VA_W-1:0]   tag_val
);
    state_e state_q, state_d;

    logic              bypass, real_lk, priv_d, amask_d;
    logic [PART_W-1:0] part_d;
    logic [CTX_W-1:0]  ctx_d;
    logic [VA_W-1:0]   va_eff;
    logic              misaligned, out_of_range;
    logic [PA_W-1:0]   merged_pa;

    logic [VA_W-1:0]   cap_va;
    logic [CTX_W-1:0]  cap_ctx;
    logic [PART_W-1:0] cap_part;
    logic              cap_real, cap_priv;
    fault_e            res_fault;
    logic [PA_W-1:0]   res_pa;
    logic [VA_W-1:0]   res_tag;
    logic              res_tag_we;

    itfx_ctl_decode u_decode (
        .ctl_word (ctl_word),
        .bypass   (bypass),
        .real_lk  (real_lk),
        .priv     (priv_d),
        .amask    (amask_d),
        .part     (part_d),
        .ctx_sel  (ctx_d)
    );

    itfx_addr_check #(.VA_W(VA_W), .VA_IMPL(VA_IMPL)) u_check (
        .va_in        (req_vaddr),
        .amask        (amask_d),
        .va_eff       (va_eff),
        .misaligned   (misaligned),
        .out_of_range (out_of_range)
    );

    itfx_page_merge #(
        .PA_W(PA_W), .PSZ_W(PSZ_W), .PAGE_BASE(PAGE_BASE), .PAGE_STEP(PAGE_STEP)
    ) u_merge (
        .frame  (tlb_frame),
        .psz    (tlb_psz),
        .va_low (cap_va[PA_W-1:0]),
        .paddr  (merged_pa)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: issue / early-finish / answer / retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (bypass || misaligned || out_of_range) ? ST_RESP : ST_LOOKUP;
                end
            end
            ST_LOOKUP: if (tlb_ack) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        tlb_req   = (state_q == ST_LOOKUP);
        rsp_valid = (state_q == ST_RESP);
        tag_we    = (state_q == ST_RESP) && res_tag_we;
        tlb_vaddr = cap_va;
        tlb_part  = cap_part;
        tlb_ctx   = cap_ctx;
        tlb_real  = cap_real;
        rsp_fault = res_fault;
        rsp_paddr = res_pa;
        tag_val   = res_tag;
    end

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_va     <= '0;
            cap_ctx    <= '0;
            cap_part   <= '0;
            cap_real   <= 1'b0;
            cap_priv   <= 1'b0;
            res_fault  <= FLT_NONE;
            res_pa     <= '0;
            res_tag    <= '0;
            res_tag_we <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            cap_va     <= va_eff;
            cap_ctx    <= ctx_d;
            cap_part   <= part_d;
            cap_real   <= real_lk;
            cap_priv   <= priv_d;
            res_tag_we <= 1'b0;
            res_pa     <= '0;
            res_fault  <= FLT_NONE;
            if (bypass) begin
                res_pa <= req_vaddr[PA_W-1:0];
            end else if (misaligned) begin
                res_fault <= FLT_ALIGN;
            end else if (out_of_range) begin
                res_fault <= FLT_RANGE;
            end
        end else if (state_q == ST_LOOKUP && tlb_ack) begin
            if (!tlb_hit || !tlb_valid) begin
                res_fault  <= FLT_MISS;
                res_tag_we <= 1'b1;
                res_tag    <= {cap_va[VA_W-1:PAGE_BASE], {PAGE_BASE{1'b0}}} | VA_W'(cap_ctx);
            end else if (!cap_priv && tlb_priv) begin
                res_fault <= FLT_PRIV;
            end else begin
                res_pa <= merged_pa;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_ack |-> tlb_req);

    assert_lookup_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req && !tlb_ack) |=> (tlb_req && $stable(tlb_vaddr) && $stable(tlb_ctx)
                                   && $stable(tlb_part) && $stable(tlb_real)));

    assert_bypass_no_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && bypass) |=> (rsp_valid && !tlb_req && rsp_fault == FLT_NONE));

    assert_align_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !bypass && misaligned) |=> (rsp_valid && rsp_fault == FLT_ALIGN));

    assert_real_ctx_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req && tlb_real) |-> (tlb_ctx == '0));

    assert_tag_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> (rsp_valid && rsp_fault == FLT_MISS));

    assert_fault_zero_pa_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_one_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, tlb_req, rsp_valid}) && (req_ready || tlb_req || rsp_valid));
endmodule

// File: tb/itfx_fetch_xlate_bench.sv
module itfx_fetch_xlate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [3:0]  rq;
        logic [63:0] ctl;
        logic [63:0] va;
        logic        hit;
        logic        vld;
        logic [39:0] frame;
        logic [1:0]  psz;
        logic        ppriv;
        logic [2:0]  e_fault;
        logic [39:0] e_pa;
        logic [63:0] e_tag;
        logic        e_lk;
        logic        e_real;
        logic [15:0] e_ctx;
        logic [7:0]  e_part;
    } vec_t;

    function automatic logic [63:0] mk_ctl(input logic hyp, rstm, pr, am, mmu,
                                           input logic [7:0] part, input logic [2:0] tl,
                                           input logic [15:0] ctx);
        return {16'h0, ctx, 13'h0, tl, part, 3'b0, mmu, am, pr, rstm, hyp};
    endfunction

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R3 hypervisor bypass, misaligned address ignored
        '{4'd3, mk_ctl(1,0,0,0,1,8'h11,3'd0,16'h42), 64'h1234_5678_9ABC_DEF1, 1'b0,1'b0, 40'h0, 2'd0, 1'b0,
          3'd0, 40'h78_9ABC_DEF1, 64'h0, 1'b0,1'b0, 16'h0, 8'h0},
        // R3 reset-state bypass, out-of-range address ignored
        '{4'd3, mk_ctl(0,1,0,0,0,8'h00,3'd3,16'h0), 64'hFFFF_FFFF_FFFF_FFFC, 1'b0,1'b0, 40'h0, 2'd0, 1'b0,
          3'd0, 40'hFF_FFFF_FFFC, 64'h0, 1'b0,1'b0, 16'h0, 8'h0},
        // R4 misaligned
        '{4'd4, mk_ctl(0,0,1,0,1,8'h05,3'd0,16'h10), 64'h4002, 1'b1,1'b1, 40'h0, 2'd0, 1'b0,
          3'd1, 40'h0, 64'h0, 1'b0,1'b0, 16'h0, 8'h0},
        // R5 out of range
        '{4'd5, mk_ctl(0,0,1,0,1,8'h05,3'd0,16'h10), 64'h0001_0000_0000_0000, 1'b1,1'b1, 40'h0, 2'd0, 1'b0,
          3'd2, 40'h0, 64'h0, 1'b0,1'b0, 16'h0, 8'h0},
        // R9 upper-half address, 8K page, primary context (R2)
        '{4'd9, mk_ctl(0,0,1,0,1,8'h5A,3'd0,16'h0ABC), 64'hFFFF_8000_0000_1A4C, 1'b1,1'b1, 40'h12_3456_7FFF, 2'd0, 1'b0,
          3'd0, 40'h12_3456_7A4C, 64'h0, 1'b1,1'b0, 16'h0ABC, 8'h5A},
        // R5 address mask truncates, 64K page, trap level 2 gives context 0 (R2)
        '{4'd5, mk_ctl(0,0,1,1,1,8'h33,3'd2,16'h0ABC), 64'hDEAD_0000_0001_2344, 1'b1,1'b1, 40'hAB_CDEF_1234, 2'd1, 1'b0,
          3'd0, 40'hAB_CDEF_2344, 64'h0, 1'b1,1'b0, 16'h0, 8'h33},
        // R6 MMU off: real lookup, context 0, 4M page
        '{4'd6, mk_ctl(0,0,1,0,0,8'h07,3'd0,16'h0777), 64'h4012_3458, 1'b1,1'b1, 40'h55_5555_5555, 2'd3, 1'b0,
          3'd0, 40'h55_5552_3458, 64'h0, 1'b1,1'b1, 16'h0, 8'h07},
        // R7 miss, primary context in tag
        '{4'd7, mk_ctl(0,0,1,0,1,8'h01,3'd0,16'h0123), 64'h0000_7FFF_FFFF_E008, 1'b0,1'b1, 40'h0, 2'd0, 1'b0,
          3'd3, 40'h0, 64'h0000_7FFF_FFFF_E123, 1'b1,1'b0, 16'h0123, 8'h01},
        // R7 miss at trap level 1, nucleus context 0
        '{4'd7, mk_ctl(0,0,1,0,1,8'h01,3'd1,16'h0123), 64'h0003_5FFC, 1'b0,1'b1, 40'h0, 2'd0, 1'b0,
          3'd3, 40'h0, 64'h0003_4000, 1'b1,1'b0, 16'h0, 8'h01},
        // R7 match on an invalid entry counts as a miss
        '{4'd7, mk_ctl(0,0,1,0,1,8'h02,3'd0,16'h0200), 64'h2000, 1'b1,1'b0, 40'h12_0000_0000, 2'd0, 1'b0,
          3'd3, 40'h0, 64'h2200, 1'b1,1'b0, 16'h0200, 8'h02},
        // R8 user fetch to privileged page
        '{4'd8, mk_ctl(0,0,0,0,1,8'h02,3'd0,16'h0005), 64'h8000, 1'b1,1'b1, 40'h00_0000_A000, 2'd0, 1'b1,
          3'd4, 40'h0, 64'h0, 1'b1,1'b0, 16'h0005, 8'h02},
        // R9 user fetch to user page, 512K page
        '{4'd9, mk_ctl(0,0,0,0,1,8'h02,3'd0,16'h0005), 64'h0007_FFFC, 1'b1,1'b1, 40'h01_0000_0000, 2'd2, 1'b0,
          3'd0, 40'h01_0007_FFFC, 64'h0, 1'b1,1'b0, 16'h0005, 8'h02},
        // R4 misalignment wins over out-of-range
        '{4'd4, mk_ctl(0,0,1,0,1,8'h00,3'd0,16'h0), 64'h8000_0000_0000_0001, 1'b1,1'b1, 40'h0, 2'd0, 1'b0,
          3'd1, 40'h0, 64'h0, 1'b0,1'b0, 16'h0, 8'h0},
        // R8 privileged fetch to privileged page is allowed
        '{4'd8, mk_ctl(0,0,1,0,1,8'h02,3'd0,16'h0005), 64'hC000, 1'b1,1'b1, 40'h00_0000_E000, 2'd0, 1'b1,
          3'd0, 40'h00_0000_E000, 64'h0, 1'b1,1'b0, 16'h0005, 8'h02}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [63:0] ctl_word = '0;
    logic        tlb_req;
    logic [63:0] tlb_vaddr;
    logic [7:0]  tlb_part;
    logic [15:0] tlb_ctx;
    logic        tlb_real;
    logic        tlb_ack;
    logic        ack_en = 1'b1;
    logic        cur_hit = 1'b0, cur_vld = 1'b0, cur_ppriv = 1'b0;
    logic [39:0] cur_frame = '0;
    logic [1:0]  cur_psz = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [39:0] rsp_paddr;
    logic        tag_we;
    logic [63:0] tag_val;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign tlb_ack = tlb_req && ack_en;

    itfx_fetch_xlate u_itfx_fetch_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .ctl_word(ctl_word), .tlb_req(tlb_req),
        .tlb_vaddr(tlb_vaddr), .tlb_part(tlb_part), .tlb_ctx(tlb_ctx),
        .tlb_real(tlb_real), .tlb_ack(tlb_ack), .tlb_hit(cur_hit),
        .tlb_valid(cur_vld), .tlb_frame(cur_frame), .tlb_psz(cur_psz),
        .tlb_priv(cur_ppriv), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .tag_we(tag_we), .tag_val(tag_val)
    );

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic load_vec(input vec_t v);
        ctl_word  = v.ctl;
        req_vaddr = v.va;
        cur_hit   = v.hit;
        cur_vld   = v.vld;
        cur_frame = v.frame;
        cur_psz   = v.psz;
        cur_ppriv = v.ppriv;
    endtask

    task automatic run_vec(input vec_t v);
        bit          got = 0, saw = 0, lk_real = 0;
        logic [15:0] lk_ctx = '0;
        logic [7:0]  lk_part = '0;
        logic [2:0]  f = '0;
        logic [39:0] pa = '0;
        logic        twe = 1'b0;
        logic [63:0] tv = '0;
        @(negedge clk);
        load_vec(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 8 && !got; k++) begin
            if (tlb_req) begin
                saw = 1; lk_real = tlb_real; lk_ctx = tlb_ctx; lk_part = tlb_part;
            end
            if (rsp_valid) begin
                got = 1; f = rsp_fault; pa = rsp_paddr; twe = tag_we; tv = tag_val;
            end else begin
                @(negedge clk);
            end
        end
        chk(got, 10, "response seen", 64'(got), 64'd1);
        chk(f == v.e_fault, int'(v.rq), "fault code", 64'(f), 64'(v.e_fault));
        chk(pa == v.e_pa, int'(v.rq), "physical address", 64'(pa), 64'(v.e_pa));
        chk(twe == (v.e_fault == 3'd3), 7, "tag write strobe", 64'(twe), 64'(v.e_fault == 3'd3));
        if (v.e_fault == 3'd3) chk(tv == v.e_tag, 7, "tag value", tv, v.e_tag);
        chk(saw == v.e_lk, int'(v.rq), "lookup issued", 64'(saw), 64'(v.e_lk));
        if (v.e_lk) begin
            chk(lk_real == v.e_real, 6, "real lookup", 64'(lk_real), 64'(v.e_real));
            chk(lk_ctx == v.e_ctx, 2, "lookup context", 64'(lk_ctx), 64'(v.e_ctx));
            chk(lk_part == v.e_part, 2, "lookup partition", 64'(lk_part), 64'(v.e_part));
        end
        @(negedge clk);
        chk(!rsp_valid, 10, "single response pulse", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog expired: actual 0x0 expected 0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, 1, "ready in reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, 1, "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        chk(tlb_req == 1'b0, 1, "tlb_req in reset", 64'(tlb_req), 64'd0);
        chk(tag_we == 1'b0, 1, "tag_we in reset", 64'(tag_we), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !tlb_req, 1, "idle after reset",
            64'({req_ready, rsp_valid, tlb_req}), 64'b100);

        // vector table walk
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2 / R10: held lookup while the buffer withholds the acknowledge
        ack_en = 1'b0;
        @(negedge clk);
        load_vec(VECS[4]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(tlb_req == 1'b1, 2, "lookup held", 64'(tlb_req), 64'd1);
        chk(tlb_vaddr == VECS[4].va, 2, "held lookup address", tlb_vaddr, VECS[4].va);
        chk(!rsp_valid && !req_ready, 10, "no response or ready while waiting",
            64'({rsp_valid, req_ready}), 64'd0);
        ack_en = 1'b1;
        @(negedge clk);
        chk(rsp_valid && rsp_paddr == VECS[4].e_pa, 9, "late answer merged",
            64'(rsp_paddr), 64'(VECS[4].e_pa));
        @(negedge clk);

        // R1: reset in the middle of a lookup drops it
        ack_en = 1'b0;
        load_vec(VECS[7]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(tlb_req == 1'b1, 1, "lookup pending before reset", 64'(tlb_req), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!tlb_req && req_ready && !rsp_valid, 1, "lookup dropped by reset",
            64'({tlb_req, req_ready, rsp_valid}), 64'b010);
        rst_n = 1'b1;
        ack_en = 1'b1;
        @(negedge clk);
        chk(!tag_we && !rsp_valid, 1, "no stale response after reset",
            64'({tag_we, rsp_valid}), 64'd0);

        // R10: a fresh request after reset still completes
        run_vec(VECS[11]);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule